// File: doc/BRIEF.md
# Wiper Position Bank with Serial Stepping

This block keeps the wiper position of four digitally controlled potentiometers. Each potentiometer owns an 8-bit position register whose value picks one of 256 taps: code 00h is the tap closest to the low terminal, and FFh is the tap closest to the high terminal. Next to each register sits a registered one-hot tap decoder. That decoder drives the switch matrix of the resistor string, which lies outside this block.

The command decoder upstream presents single-cycle strobes. There are four of them.
- A power-up recall loads every position from its stored default, data register 0.
- A host write sets one position directly.
- A transfer loads one position, or all four at once, from the data register the decoder has selected.
- A stepping arm picks one potentiometer.

After the arm, every qualified serial clock pulse moves the chosen wiper one tap. The level of the serial data line samples the direction: up when high, down when low. Stepping ends at the end of the frame.

All inputs are plain control strobes that are taken in the cycle they appear. Nothing at this boundary applies back-pressure, so there is no valid/ready pair. The upstream decoder must present each strobe for exactly one clock per event. The registers are volatile and hold zero after reset until a recall arrives.

Top module: `wiper_bank`

## Requirements
- R1: After reset every position reads 00h and every tap-select group has only bit 0 set.
- R2: A recall strobe loads every position from its 8-bit slice of the recall bus (pot n at bits 8n+7..8n) on the next clock. A recall also ends stepping mode.
- R3: A write strobe loads the write data into the position of the pot named by the 2-bit write index, on the next clock. All other pots are left unchanged.
- R4: A transfer strobe with the global flag low loads only the pot named by the transfer index, from its slice of the transfer bus. With the global flag high, the strobe loads all four pots from their slices.
- R5: An arm strobe enables stepping on the pot named by the arm index from the following cycle onward. Each step pulse then adds 1 to that pot's position when the direction input is 1, and subtracts 1 when it is 0. No other pot moves.
- R6: Stepping saturates. An up step at FFh leaves FFh, and a down step at 00h leaves 00h.
- R7: Step pulses have no effect when stepping is not enabled. A frame-end strobe disables stepping, and a pulse in the same cycle as a frame end is ignored. When frame end and arm fall in the same cycle, frame end wins.
- R8: When loads collide on one pot in one cycle, the priority is recall, then write, then transfer, then step.
- R9: Each pot's 256-bit tap select is one-hot. Its set bit index equals the position value one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recall_req | input | 1 | Power-up recall strobe |
| recall_data | input | 32 | Default value per pot, pot n in bits 8n+7..8n |
| wr_strobe | input | 1 | Host write strobe |
| wr_pot | input | 2 | Pot addressed by the write |
| wr_data | input | 8 | Value to write |
| xfr_strobe | input | 1 | Data-register transfer strobe |
| xfr_all | input | 1 | 1 = load all pots, 0 = only the indexed pot |
| xfr_pot | input | 2 | Pot addressed by a single transfer |
| xfr_data | input | 32 | Selected data register value per pot |
| step_arm | input | 1 | Enter stepping mode |
| step_arm_pot | input | 2 | Pot to be stepped |
| frame_end | input | 1 | Chip-select release, ends stepping |
| step_pulse | input | 1 | One qualified serial clock pulse |
| step_up | input | 1 | Sampled serial data level: 1 up, 0 down |
| wiper | output | 32 | Current positions, pot n in bits 8n+7..8n |
| tap_sel | output | 1024 | One-hot tap selects, pot n in bits 256n+255..256n |

## Verification
The hardest situations to reach from the ports are the saturation edges and the one-cycle collisions. Random stepping rarely walks a position all the way to FFh or 00h. It also rarely makes a recall, a write and a transfer land on the same pot in the same clock. The stimulus therefore writes positions one tap short of each end, arms stepping and drives runs of pulses through the limit. It also builds the collision cycles on purpose. Long random runs are then mixed in, with strobes overlapping freely, to cover frame-end, arm and pulse interleavings.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  // Source that wins the next-value select of one position register.
  typedef enum logic [2:0] {
    SRC_HOLD   = 3'd0,
    SRC_STEP   = 3'd1,
    SRC_XFR    = 3'd2,
    SRC_WRITE  = 3'd3,
    SRC_RECALL = 3'd4
  } wiper_src_e;
endpackage

// File: rtl/wiper_step_ctl.sv
module wiper_step_ctl #(
  parameter int NUM_POTS = 4,
  localparam int POT_SEL_W = $clog2(NUM_POTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 recall_req,
  input  logic                 step_arm,
  input  logic [POT_SEL_W-1:0] step_arm_pot,
  input  logic                 frame_end,
  input  logic                 step_pulse,
  output logic [NUM_POTS-1:0]  step_en
);
  logic                 mode_q;
  logic [POT_SEL_W-1:0] pot_q;

  // Frame end and recall clear the mode; arm takes effect next cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      pot_q  <= '0;
    end else if (recall_req || frame_end) begin
      mode_q <= 1'b0;
    end else if (step_arm) begin
      mode_q <= 1'b1;
      pot_q  <= step_arm_pot;
    end
  end

  for (genvar p = 0; p < NUM_POTS; p++) begin : g_en
    assign step_en[p] = mode_q && step_pulse && !frame_end &&
                        (pot_q == POT_SEL_W'(p));
  end
endmodule

// File: rtl/wiper_cell.sv
module wiper_cell
  import wiper_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recall_hit,
  input  logic [POS_W-1:0] recall_val,
  input  logic             wr_hit,
  input  logic [POS_W-1:0] wr_val,
  input  logic             xfr_hit,
  input  logic [POS_W-1:0] xfr_val,
  input  logic             step_en,
  input  logic             step_up,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [POS_W-1:0] POS_MIN = '0;

  wiper_src_e       src;
  logic [POS_W-1:0] stepped;
  logic [POS_W-1:0] pos_d;
  logic [POS_W-1:0] pos_q;

  always_comb begin
    if (recall_hit)   src = SRC_RECALL;
    else if (wr_hit)  src = SRC_WRITE;
    else if (xfr_hit) src = SRC_XFR;
    else if (step_en) src = SRC_STEP;
    else              src = SRC_HOLD;
  end

  // Saturating one-tap move.
  always_comb begin
    stepped = pos_q;
    if (step_up) begin
      if (pos_q != POS_MAX) stepped = pos_q + POS_W'(1);
    end else begin
      if (pos_q != POS_MIN) stepped = pos_q - POS_W'(1);
    end
  end

  always_comb begin
    unique case (src)
      SRC_RECALL: pos_d = recall_val;
      SRC_WRITE:  pos_d = wr_val;
      SRC_XFR:    pos_d = xfr_val;
      SRC_STEP:   pos_d = stepped;
      default:    pos_d = pos_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos = pos_q;
endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
  parameter int POS_W = 8,
  localparam int TAPS = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  taps
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps <= TAPS'(1);
    else        taps <= TAPS'(1) << pos;
  end
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank #(
  parameter int NUM_POTS = 4,
  parameter int POS_W = 8,
  localparam int POT_SEL_W = $clog2(NUM_POTS),
  localparam int TAPS = 1 << POS_W,
  localparam int BUS_W = NUM_POTS * POS_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     recall_req,
  input  logic [BUS_W-1:0]         recall_data,
  input  logic                     wr_strobe,
  input  logic [POT_SEL_W-1:0]     wr_pot,
  input  logic [POS_W-1:0]         wr_data,
  input  logic                     xfr_strobe,
  input  logic                     xfr_all,
  input  logic [POT_SEL_W-1:0]     xfr_pot,
  input  logic [BUS_W-1:0]         xfr_data,
  input  logic                     step_arm,
  input  logic [POT_SEL_W-1:0]     step_arm_pot,
  input  logic                     frame_end,
  input  logic                     step_pulse,
  input  logic                     step_up,
  output logic [BUS_W-1:0]         wiper,
  output logic [NUM_POTS*TAPS-1:0] tap_sel
);
  logic [NUM_POTS-1:0] step_en;

  wiper_step_ctl #(.NUM_POTS(NUM_POTS)) u_step_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .recall_req   (recall_req),
    .step_arm     (step_arm),
    .step_arm_pot (step_arm_pot),
    .frame_end    (frame_end),
    .step_pulse   (step_pulse),
    .step_en      (step_en)
  );

  for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
    logic wr_hit;
    logic xfr_hit;
    assign wr_hit  = wr_strobe && (wr_pot == POT_SEL_W'(p));
    assign xfr_hit = xfr_strobe && (xfr_all || (xfr_pot == POT_SEL_W'(p)));

    wiper_cell #(.POS_W(POS_W)) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .recall_hit (recall_req),
      .recall_val (recall_data[p*POS_W +: POS_W]),
      .wr_hit     (wr_hit),
      .wr_val     (wr_data),
      .xfr_hit    (xfr_hit),
      .xfr_val    (xfr_data[p*POS_W +: POS_W]),
      .step_en    (step_en[p]),
      .step_up    (step_up),
      .pos        (wiper[p*POS_W +: POS_W])
    );

    wiper_tap_decode #(.POS_W(POS_W)) u_decode (
      .clk   (clk),
      .rst_n (rst_n),
      .pos   (wiper[p*POS_W +: POS_W]),
      .taps  (tap_sel[p*TAPS +: TAPS])
    );
  end
endmodule

// File: rtl/wiper_bank_checker.sv
module wiper_bank_checker #(
  parameter int NUM_POTS = 4,
  parameter int POS_W = 8,
  localparam int POT_SEL_W = $clog2(NUM_POTS),
  localparam int TAPS = 1 << POS_W,
  localparam int BUS_W = NUM_POTS * POS_W
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     recall_req,
  input logic [BUS_W-1:0]         recall_data,
  input logic                     wr_strobe,
  input logic [POT_SEL_W-1:0]     wr_pot,
  input logic [POS_W-1:0]         wr_data,
  input logic                     xfr_strobe,
  input logic                     xfr_all,
  input logic [POT_SEL_W-1:0]     xfr_pot,
  input logic [BUS_W-1:0]         xfr_data,
  input logic                     step_pulse,
  input logic [BUS_W-1:0]         wiper,
  input logic [NUM_POTS*TAPS-1:0] tap_sel
);
  a_r2_recall_all: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |=> wiper == $past(recall_data));

  for (genvar p = 0; p < NUM_POTS; p++) begin : g_chk
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(tap_sel[p*TAPS +: TAPS]));

    a_r9_follow: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> tap_sel[p*TAPS +: TAPS] == (TAPS'(1) << $past(wiper[p*POS_W +: POS_W])));

    a_r3_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe && !recall_req && wr_pot == POT_SEL_W'(p))
      |=> wiper[p*POS_W +: POS_W] == $past(wr_data));

    // R4 with R8 ordering: transfer applies only when no write hits this pot
    a_r4_xfr: assert property (@(posedge clk) disable iff (!rst_n)
      (xfr_strobe && !recall_req && !(wr_strobe && wr_pot == POT_SEL_W'(p)) &&
       (xfr_all || xfr_pot == POT_SEL_W'(p)))
      |=> wiper[p*POS_W +: POS_W] == $past(xfr_data[p*POS_W +: POS_W]));

    a_r6_one_tap: assert property (@(posedge clk) disable iff (!rst_n)
      (!recall_req && !wr_strobe && !xfr_strobe)
      |=> (32'(wiper[p*POS_W +: POS_W]) == 32'($past(wiper[p*POS_W +: POS_W])) ||
           32'(wiper[p*POS_W +: POS_W]) == 32'($past(wiper[p*POS_W +: POS_W])) + 1 ||
           32'(wiper[p*POS_W +: POS_W]) + 1 == 32'($past(wiper[p*POS_W +: POS_W]))));

    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!recall_req && !wr_strobe && !xfr_strobe && !step_pulse)
      |=> $stable(wiper[p*POS_W +: POS_W]));
  end
endmodule

bind wiper_bank wiper_bank_checker #(.NUM_POTS(NUM_POTS), .POS_W(POS_W)) u_wiper_bank_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .recall_req  (recall_req),
  .recall_data (recall_data),
  .wr_strobe   (wr_strobe),
  .wr_pot      (wr_pot),
  .wr_data     (wr_data),
  .xfr_strobe  (xfr_strobe),
  .xfr_all     (xfr_all),
  .xfr_pot     (xfr_pot),
  .xfr_data    (xfr_data),
  .step_pulse  (step_pulse),
  .wiper       (wiper),
  .tap_sel     (tap_sel)
);

// File: tb/test_wiper_bank.sv
`timescale 1ns/1ps
module test_wiper_bank;
  localparam int NP = 4;
  localparam int PW = 8;
  localparam int TAPS = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recall_req = 0, wr_strobe = 0, xfr_strobe = 0, xfr_all = 0;
  logic step_arm = 0, frame_end = 0, step_pulse = 0, step_up = 0;
  logic [1:0] wr_pot = 0, xfr_pot = 0, step_arm_pot = 0;
  logic [7:0] wr_data = 0;
  logic [31:0] recall_data = 0, xfr_data = 0;
  logic [31:0] wiper;
  logic [NP*TAPS-1:0] tap_sel;

  always #5 clk = ~clk;

  wiper_bank i_wiper_bank (
    .clk(clk), .rst_n(rst_n), .recall_req(recall_req), .recall_data(recall_data),
    .wr_strobe(wr_strobe), .wr_pot(wr_pot), .wr_data(wr_data),
    .xfr_strobe(xfr_strobe), .xfr_all(xfr_all), .xfr_pot(xfr_pot), .xfr_data(xfr_data),
    .step_arm(step_arm), .step_arm_pot(step_arm_pot), .frame_end(frame_end),
    .step_pulse(step_pulse), .step_up(step_up), .wiper(wiper), .tap_sel(tap_sel)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] m_w [NP];
  logic [7:0] m_prev [NP];
  bit m_mode = 0;
  logic [1:0] m_pot = 0;

  function automatic logic [7:0] sat_move(logic [7:0] v, logic up);
    if (up) return (v == 8'hFF) ? v : v + 8'd1;
    return (v == 8'h00) ? v : v - 8'd1;
  endfunction

  function automatic logic [TAPS-1:0] onehot(logic [7:0] v);
    return TAPS'(1) << v;
  endfunction

  task automatic check(string req, string what, logic [TAPS-1:0] act, logic [TAPS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Model update per R2..R8, applied with inputs seen at the clock edge.
  task automatic model_apply();
    for (int p = 0; p < NP; p++) m_prev[p] = m_w[p];
    for (int p = 0; p < NP; p++) begin
      if (recall_req) m_w[p] = recall_data[p*8 +: 8];
      else if (wr_strobe && wr_pot == 2'(p)) m_w[p] = wr_data;
      else if (xfr_strobe && (xfr_all || xfr_pot == 2'(p))) m_w[p] = xfr_data[p*8 +: 8];
      else if (m_mode && step_pulse && !frame_end && m_pot == 2'(p))
        m_w[p] = sat_move(m_prev[p], step_up);
    end
    if (recall_req || frame_end) m_mode = 0;
    else if (step_arm) begin m_mode = 1; m_pot = step_arm_pot; end
  endtask

  task automatic clear_in();
    recall_req = 0; wr_strobe = 0; xfr_strobe = 0; xfr_all = 0;
    step_arm = 0; frame_end = 0; step_pulse = 0;
  endtask

  task automatic tick(string req);
    @(posedge clk);
    model_apply();
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      check(req, "wiper", TAPS'(wiper[p*8 +: 8]), TAPS'(m_w[p]));
      check("R9", "tap_sel", tap_sel[p*TAPS +: TAPS], onehot(m_prev[p]));
    end
    clear_in();
  endtask

  task automatic write_pot(logic [1:0] p, logic [7:0] v);
    wr_strobe = 1; wr_pot = p; wr_data = v; tick("R3");
  endtask

  task automatic arm(logic [1:0] p);
    step_arm = 1; step_arm_pot = p; tick("R5");
  endtask

  task automatic pulse(logic up, string req);
    step_pulse = 1; step_up = up; tick(req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < NP; p++) m_w[p] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int p = 0; p < NP; p++) begin
      check("R1", "wiper", TAPS'(wiper[p*8 +: 8]), '0);
      check("R1", "tap_sel", tap_sel[p*TAPS +: TAPS], TAPS'(1));
    end
    // R2 recall
    recall_data = 32'h80_40_C0_10; recall_req = 1; tick("R2");
    // R6 saturation at the top
    write_pot(2'd1, 8'hFE); arm(2'd1);
    pulse(1, "R5"); pulse(1, "R6"); pulse(1, "R6");
    // R5 down on armed pot only; retarget to pot 2, saturate at bottom
    pulse(0, "R5");
    write_pot(2'd2, 8'h01); arm(2'd2);
    pulse(0, "R5"); pulse(0, "R6"); pulse(0, "R6"); pulse(1, "R5");
    // R7 pulse with frame end ignored, then pulses after frame end ignored
    frame_end = 1; step_pulse = 1; step_up = 1; tick("R7");
    pulse(1, "R7"); pulse(0, "R7");
    step_arm = 1; frame_end = 1; tick("R7");
    pulse(1, "R7");
    // R8 priority collisions
    recall_data = 32'h11_22_33_44; recall_req = 1; wr_strobe = 1; wr_pot = 0;
    wr_data = 8'hAA; tick("R8");
    wr_strobe = 1; wr_pot = 3; wr_data = 8'h5A; xfr_strobe = 1; xfr_all = 1;
    xfr_data = 32'h01_02_03_04; tick("R8");
    arm(2'd0);
    xfr_strobe = 1; xfr_pot = 0; xfr_data = 32'h00_00_00_77; step_pulse = 1; step_up = 1;
    tick("R8");
    // R4 single and global transfers
    xfr_strobe = 1; xfr_pot = 2; xfr_data = 32'hDE_AD_BE_EF; tick("R4");
    xfr_strobe = 1; xfr_all = 1; xfr_data = 32'hFF_00_7F_80; tick("R4");
    frame_end = 1; tick("R7");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      string tag;
      tag = "R5";
      step_pulse = ($urandom % 100) < 70;
      step_up = $urandom % 2;
      if (($urandom % 100) < 6) begin step_arm = 1; step_arm_pot = 2'($urandom); end
      if (($urandom % 100) < 4) begin frame_end = 1; tag = "R7"; end
      if (($urandom % 100) < 8) begin
        xfr_strobe = 1; xfr_all = $urandom % 2; xfr_pot = 2'($urandom);
        xfr_data = $urandom; tag = "R4";
      end
      if (($urandom % 100) < 8) begin
        wr_strobe = 1; wr_pot = 2'($urandom); wr_data = 8'($urandom); tag = "R3";
      end
      if (($urandom % 100) < 2) begin recall_req = 1; recall_data = $urandom; tag = "R2"; end
      tick(tag);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule